// File: doc/BRIEF.md
# Eight-Channel DAC Serial Command Decoder

This block is the digital core of an eight-channel voltage-output converter. A host drives three wires: a frame strobe that is active low, a serial clock and a data line. While the strobe is low, each rising serial-clock edge shifts one data bit into a 32-bit register. When the strobe returns high, the block reads the newest 24 bits as a command, then a channel address, then a 16-bit code, and acts on them. Each channel holds a staged code and an active code. Writes go to the staged code, and updates copy staged codes into active codes. Each channel can also be put to sleep on its own and woken again. The newest 24 bits may be preceded by eight unused bits, so the host can send either 24-bit or 32-bit words.

The serial pins are brought into the system clock domain through two-stage synchronizers, so the system clock must run at least four times faster than the serial clock. The oldest bit of the shift register is driven on a data-out pin, which lets several devices be chained on one port. A per-channel ready flag models the wake-up time of the analog channel in system clock cycles. The wake-up time is longer when the whole device was asleep. An asynchronous clear input that is active low zeroes the staged and active codes.

Top module: `dac8_serial_ctrl`

## Requirements
- R1: Bits are shifted in only on rising serial-clock edges while the strobe is low. Serial-clock edges while the strobe is high leave the shift register unchanged.
- R2: On the strobe's rising edge, the newest 24 shifted bits decode as command (bits 23:20), address (bits 19:16) and code (bits 15:0), each sent MSB first. Any earlier bits are ignored. If fewer than 24 bits were shifted in the frame, no register changes.
- R3: Command 0x0 loads the code into the staged register of the addressed channel(s). No active code changes.
- R4: Command 0x1 copies the staged code into the active code of the addressed channel(s) and wakes them.
- R5: Command 0x2 loads the code into the staged register of the addressed channel(s). It then copies staged codes into active codes on all eight channels and wakes all eight.
- R6: Command 0x3 loads the code into both the staged and active registers of the addressed channel(s) and wakes them.
- R7: Command 0x4 puts the addressed channel(s) to sleep and ignores the code field. Staged and active codes are kept.
- R8: Address values 0x0 to 0x7 select one channel, and address 0xF selects all eight. Any other address, any command outside {0x0–0x4, 0xF}, and command 0xF itself change nothing.
- R9: Reset gives all-zero codes, all channels awake and ready, and data-out low. While the clear input is low, every staged and active code is held at zero. Sleep flags are not touched by clear.
- R10: Data-out equals the bit shifted in 32 shifts earlier. It changes only after a falling serial-clock edge, and it is driven whatever the strobe level.
- R11: The ready flag is low while a channel sleeps. After a channel is woken, ready stays low for SHORT_WAIT cycles if at least one channel was awake, or LONG_WAIT cycles if all eight were asleep.
- R12: With a resolution RES below 16, the active code is the top RES bits of the 16-bit code field. The low bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| clr_n | input | 1 | Code clear, active low, asynchronous, level held |
| cs_ld | input | 1 | Frame strobe; low to shift, rising edge executes |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out for chaining |
| dac_code | output | 8*RES | Active codes, channel k at bits k*RES +: RES |
| dac_off | output | 8 | Per-channel sleep flags |
| dac_ready | output | 8 | Per-channel ready flags |

## Verification
Directed frames exercise each command against a known staged/active state, so that staging, activation and waking can be told apart. They also cover 24-bit words, 32-bit words with random leading bits, a 64-bit chained frame and a 20-bit short frame, which together show that only the newest 24 bits matter and that short frames do nothing. Reserved addresses and commands, stray serial clocks while the strobe is high, and a clear pulse isolate the no-change paths. Wake-up delays are counted cycle by cycle for both a partial and a full sleep. A randomized mix of all commands, addresses and frame lengths then runs against a bench model. Throughout, data-out is compared bit by bit with the history of shifted bits, and a second instance with 12-bit resolution checks truncation.

// File: rtl/dac8_serial_ctrl.sv
`timescale 1ns/1ps
module dac8_serial_ctrl #(
  parameter int RES        = 16,
  parameter int SHORT_WAIT = 1250,
  parameter int LONG_WAIT  = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             cs_ld,
  input  logic             sck,
  input  logic             sdi,
  output logic             sdo,
  output logic [8*RES-1:0] dac_code,
  output logic [7:0]       dac_off,
  output logic [7:0]       dac_ready
);
  localparam int NCH = 8;
  localparam int TW  = $clog2(LONG_WAIT + 1);
  localparam logic [TW-1:0] T_SHORT = TW'(SHORT_WAIT);
  localparam logic [TW-1:0] T_LONG  = TW'(LONG_WAIT);

  logic [2:0] sck_p, cs_p;
  logic [1:0] sdi_p;
  logic [31:0] sr;
  logic [4:0] nbits;
  logic sdo_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= 3'b000;
      cs_p  <= 3'b111;
      sdi_p <= 2'b00;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      cs_p  <= {cs_p[1:0], cs_ld};
      sdi_p <= {sdi_p[0], sdi};
    end

  wire sck_rise = sck_p[1] & ~sck_p[2];
  wire sck_fall = ~sck_p[1] & sck_p[2];
  wire cs_s     = cs_p[1];
  wire exec     = cs_p[1] & ~cs_p[2] & (nbits == 5'd24);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr    <= '0;
      nbits <= '0;
      sdo_q <= 1'b0;
    end else begin
      if (cs_s) nbits <= '0;
      else if (sck_rise) begin
        sr    <= {sr[30:0], sdi_p[1]};
        nbits <= (nbits == 5'd24) ? nbits : nbits + 5'd1;
      end
      if (sck_fall) sdo_q <= sr[31];
    end

  assign sdo = sdo_q;

  wire [3:0]     cmd  = sr[23:20];
  wire [3:0]     adr  = sr[19:16];
  wire [RES-1:0] word = sr[15 -: RES];

  logic [NCH-1:0] sel;
  always_comb begin
    sel = '0;
    if (&adr) sel = '1;
    else if (!adr[3]) sel[adr[2:0]] = 1'b1;
  end

  wire go = exec & (~adr[3] | (&adr));
  wire [NCH-1:0] wr_m = (go && (cmd == 4'h0 || cmd == 4'h2 || cmd == 4'h3)) ? sel : '0;
  wire [NCH-1:0] up_m = !go ? '0 :
                        (cmd == 4'h2) ? '1 :
                        (cmd == 4'h1 || cmd == 4'h3) ? sel : '0;
  wire [NCH-1:0] dn_m = (go && cmd == 4'h4) ? sel : '0;
  wire all_down = &dac_off;
  wire clr_all  = rst_n & clr_n;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [RES-1:0] in_r, act_r;
    logic [TW-1:0]  tmr;
    logic           pd_q;

    always_ff @(posedge clk or negedge clr_all)
      if (!clr_all) begin
        in_r  <= '0;
        act_r <= '0;
      end else begin
        if (wr_m[i]) in_r <= word;
        if (up_m[i]) act_r <= wr_m[i] ? word : in_r;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pd_q <= 1'b0;
        tmr  <= '0;
      end else begin
        if (up_m[i]) pd_q <= 1'b0;
        else if (dn_m[i]) pd_q <= 1'b1;
        if (up_m[i] && pd_q) tmr <= all_down ? T_LONG : T_SHORT;
        else if (tmr != '0) tmr <= tmr - 1'b1;
      end

    assign dac_code[i*RES +: RES] = act_r;
    assign dac_off[i]   = pd_q;
    assign dac_ready[i] = ~pd_q & (tmr == '0);
  end
endmodule

// File: rtl/dac8_serial_ctrl_chk.sv
`timescale 1ns/1ps
module dac8_serial_ctrl_chk #(
  parameter int RES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             sck_fall,
  input logic             exec,
  input logic [3:0]       cmd,
  input logic [3:0]       adr,
  input logic             sdo,
  input logic [8*RES-1:0] dac_code,
  input logic [7:0]       dac_off,
  input logic [7:0]       dac_ready
);
  logic rsv;
  assign rsv = !((adr < 4'h8) || (adr == 4'hF)) || !((cmd <= 4'h4) || (cmd == 4'hF)) || (cmd == 4'hF);

  p_codes_only_on_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(exec) && clr_n && $past(clr_n)) |-> $stable(dac_code));

  p_sleep_keeps_codes_r7: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (exec && cmd == 4'h4) |=> $stable(dac_code));

  p_reserved_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (exec && rsv) |=> ($stable(dac_code) && $stable(dac_off)));

  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (dac_code == '0));

  p_sdo_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sck_fall) |-> $stable(sdo));

  p_ready_off_when_asleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_ready & dac_off) == 8'h00);

  p_wake_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dac_off) & ~dac_off & dac_ready) == 8'h00);
endmodule

bind dac8_serial_ctrl dac8_serial_ctrl_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sck_fall(sck_fall), .exec(exec),
  .cmd(cmd), .adr(adr), .sdo(sdo), .dac_code(dac_code), .dac_off(dac_off),
  .dac_ready(dac_ready)
);

// File: tb/dac8_serial_ctrl_bench.sv
`timescale 1ns/1ps
module dac8_serial_ctrl_bench;
  localparam int SW = 20;
  localparam int LW = 60;

  logic clk = 0, rst_n = 0, clr_n = 1, cs_ld = 1, sck = 0, sdi = 0;
  wire sdo, sdo12;
  wire [127:0] code16;
  wire [95:0]  code12;
  wire [7:0] off16, rdy16, off12, rdy12;

  always #2 clk = ~clk;

  dac8_serial_ctrl #(.RES(16), .SHORT_WAIT(SW), .LONG_WAIT(LW)) u_dac8_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_ld(cs_ld), .sck(sck), .sdi(sdi),
    .sdo(sdo), .dac_code(code16), .dac_off(off16), .dac_ready(rdy16));

  dac8_serial_ctrl #(.RES(12), .SHORT_WAIT(SW), .LONG_WAIT(LW)) u_dac8_serial_ctrl_12 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_ld(cs_ld), .sck(sck), .sdi(sdi),
    .sdo(sdo12), .dac_code(code12), .dac_off(off12), .dac_ready(rdy12));

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_in [8];
  logic [15:0] m_act [8];
  logic [7:0]  m_pd;
  logic [31:0] shadow;

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] c, input logic [3:0] a);
    if (a[3] && a != 4'hF) return "R8";
    case (c)
      4'h0: return "R3";
      4'h1: return "R4";
      4'h2: return "R5";
      4'h3: return "R6";
      4'h4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model(input logic [23:0] w);
    logic [3:0] c, a;
    logic [7:0] s;
    c = w[23:20]; a = w[19:16];
    s = (a == 4'hF) ? 8'hFF : (a[3] ? 8'h00 : (8'h01 << a[2:0]));
    for (int k = 0; k < 8; k++) begin
      if (!s[k] && c != 4'h2) continue;
      case (c)
        4'h0: m_in[k] = w[15:0];
        4'h1: begin m_act[k] = m_in[k]; m_pd[k] = 1'b0; end
        4'h2: begin
          if (s[k]) m_in[k] = w[15:0];
          if (s != 8'h00) begin m_act[k] = m_in[k]; m_pd[k] = 1'b0; end
        end
        4'h3: begin m_in[k] = w[15:0]; m_act[k] = w[15:0]; m_pd[k] = 1'b0; end
        4'h4: m_pd[k] = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic clk_bit(input logic b, input string req);
    @(negedge clk); sdi = b;
    repeat (4) @(negedge clk); sck = 1;
    shadow = {shadow[30:0], b};
    repeat (4) @(negedge clk); sck = 0;
    repeat (4) @(negedge clk);
    chk(req, {127'd0, sdo}, {127'd0, shadow[31]});
  endtask

  task automatic stray_clocks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sdi = 1; sck = 1;
      repeat (4) @(negedge clk); sck = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send(input logic [63:0] w, input int len, input string req);
    @(negedge clk); cs_ld = 0;
    repeat (2) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) clk_bit(w[i], req);
    repeat (2) @(negedge clk); cs_ld = 1;
    if (len >= 24) model(w[23:0]);
  endtask

  task automatic check_state(input string req);
    logic [127:0] e16, e12;
    repeat (8) @(negedge clk);
    e16 = '0; e12 = '0;
    for (int k = 0; k < 8; k++) begin
      e16[k*16 +: 16] = m_act[k];
      e12[k*12 +: 12] = m_act[k][15:4];
    end
    chk(req, code16, e16);
    chk({req, "/R12"}, {32'd0, code12}, e12);
    chk(req, {120'd0, off16}, {120'd0, m_pd});
  endtask

  task automatic wake_len(input int ch, output int n);
    n = 0;
    repeat (LW + 30) begin
      @(negedge clk);
      if (!off16[ch] && !rdy16[ch]) n++;
    end
  endtask

  function automatic logic [63:0] frame(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
    return {32'd0, 8'($urandom), c, a, d};
  endfunction

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [3:0] c, a;
    int len;
    void'($urandom(32'h5EED1234));
    shadow = '0; m_pd = '0;
    for (int k = 0; k < 8; k++) begin m_in[k] = '0; m_act[k] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    chk("R9", code16, '0);
    chk("R9", {120'd0, off16}, '0);
    chk("R9", {120'd0, rdy16}, {120'd0, 8'hFF});
    chk("R9", {127'd0, sdo}, '0);

    send(frame(4'h0, 4'h3, 16'hABCD), 24, "R10"); check_state("R3");
    send(frame(4'h1, 4'h3, 16'h0000), 32, "R10"); check_state("R4");
    send(frame(4'h3, 4'h6, 16'h123F), 32, "R10"); check_state("R6");
    send(frame(4'h0, 4'h1, 16'h7777), 24, "R10");
    send(frame(4'h2, 4'h0, 16'h5A5A), 32, "R10"); check_state("R5");
    send(frame(4'h3, 4'h8, 16'hFFFF), 32, "R10"); check_state("R8");
    send(frame(4'h5, 4'h2, 16'hFFFF), 32, "R10"); check_state("R8");
    send(frame(4'hF, 4'hF, 16'hFFFF), 24, "R10"); check_state("R8");
    send(frame(4'h3, 4'h0, 16'h1111), 20, "R2");  check_state("R2");
    send(frame(4'h3, 4'hF, 16'h2222), 32, "R10"); check_state("R8");

    stray_clocks(8);
    send(frame(4'h3, 4'h4, 16'hC0DE), 32, "R1"); check_state("R1");
    send({frame(4'h3, 4'h7, 16'hDEAD)[31:0], frame(4'h3, 4'h2, 16'hBEEF)[31:0]}, 64, "R10");
    check_state("R2");

    send(frame(4'h4, 4'h2, 16'h9999), 24, "R10"); check_state("R7");
    chk("R11", {127'd0, rdy16[2]}, '0);
    send(frame(4'h1, 4'h2, 16'h0000), 24, "R10");
    wake_len(2, n);
    chk("R11", n, SW);
    check_state("R4");

    send(frame(4'h4, 4'hF, 16'h0000), 24, "R10"); check_state("R7");
    send(frame(4'h3, 4'h5, 16'h4321), 24, "R10");
    wake_len(5, n);
    chk("R11", n, LW);
    chk("R11", {120'd0, rdy16}, {120'd0, 8'h20});
    send(frame(4'h2, 4'h0, 16'h8765), 24, "R10");
    wake_len(0, n);
    chk("R11", n, SW);
    check_state("R5");
    chk("R11", {120'd0, rdy16}, {120'd0, 8'hFF});

    send(frame(4'h0, 4'h1, 16'h3333), 24, "R10");
    send(frame(4'h4, 4'h6, 16'h0000), 24, "R10");
    @(negedge clk); clr_n = 0;
    repeat (3) @(negedge clk);
    chk("R9", code16, '0);
    for (int k = 0; k < 8; k++) begin m_in[k] = '0; m_act[k] = '0; end
    clr_n = 1;
    check_state("R9");
    send(frame(4'h1, 4'hF, 16'h0000), 24, "R10"); check_state("R9");

    for (int t = 0; t < 120; t++) begin
      case ($urandom % 8)
        0: c = 4'h0; 1: c = 4'h1; 2: c = 4'h2; 3: c = 4'h3;
        4: c = 4'h4; 5: c = 4'hF; 6: c = 4'h0; default: c = 4'($urandom);
      endcase
      a = ($urandom % 4 == 0) ? 4'($urandom) : (($urandom % 5 == 0) ? 4'hF : 4'($urandom % 8));
      case ($urandom % 4)
        0: len = 24; 1: len = 20; default: len = 32;
      endcase
      send(frame(c, a, 16'($urandom)), len, "R10");
      check_state(len < 24 ? "R2" : tag_of(c, a));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule